// File: doc/BRIEF.md
# Per-Group Command Source Write Arbiter

This block guards writes to the control registers of one 32-bit GPIO bank word. The word is split into byte-wide pin groups, and each group carries a two-bit command source code naming the bus master allowed to change that group's value, direction, interrupt and reset-persistence bits. Each access arrives tagged with a master identifier and a target class. The arbiter passes a write through only on the byte lanes whose group is owned by the requester. A write that loses any lane it asked for is flagged as rejected. Reads and writes to the unguarded class, which holds the debounce settings, pass through untouched.

Each group's source code is kept as two separate bits, one in a low-bit register and one in a high-bit register. Both registers are written through the same access port, and only the primary processor may write them. Software moves a group from one owner to another by writing the high-bit register first. The code 11 is illegal. A group that holds it accepts writes from no master, and a sticky error flag records that the illegal code occurred.

Top module: `cmdsrc_arb`

## Requirements
- R1: After reset every group's source code is 00 (primary processor), the sticky error flag is 0, and neither fwd_valid nor wr_reject is asserted.
- R2: Target code 1 is the low-bit source register and target code 2 is the high-bit source register. A write to either by master 0 sets group g's bit to acc_data bit g*8, but only for groups whose acc_be lane g is set. src_code bits [2g+1:2g] show {high, low} for group g from the cycle after the write.
- R3: A write to either source register by any master other than 0 changes no source bit, is not forwarded, and raises wr_reject.
- R4: Master codes are 0 primary processor, 1 host bus, 2 coprocessor and 3 reserved. A write to the guarded target (code 0) by the master whose code equals a group's source code is forwarded with that lane enabled, with the data, write flag and target unchanged, and without a reject.
- R5: A guarded write that spans several groups is forwarded with fwd_be limited to the lanes the requester owns. wr_reject is raised when any requested lane is dropped. When no lane remains, fwd_valid stays low.
- R6: A read from any master to the guarded or unguarded target is forwarded with its original byte enables and is never rejected.
- R7: A write to the unguarded target (code 3) is forwarded with all requested lanes, whatever the groups' source codes.
- R8: A group whose source code is 11 grants no lane to any master, including the reserved code 3.
- R9: The error flag rises on the cycle after any group holds code 11. It stays set until err_clr is pulsed while no group holds 11. A pulse while a group still holds 11 leaves it set.
- R10: With REG_OUT=1, fwd_valid, fwd_write, fwd_target, fwd_be, fwd_data and wr_reject appear one clock after the access is presented. With REG_OUT=0 they appear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access request present this cycle |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_master | input | 2 | Requesting master code |
| acc_target | input | 2 | 0 guarded, 1 source low bits, 2 source high bits, 3 unguarded |
| acc_be | input | DATA_W/8 | Byte enables, one per group |
| acc_data | input | DATA_W | Write data |
| err_clr | input | 1 | Clears the sticky illegal-code flag |
| fwd_valid | output | 1 | Access forwarded to the register file |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_target | output | 2 | Forwarded target class |
| fwd_be | output | DATA_W/8 | Forwarded byte enables after ownership masking |
| fwd_data | output | DATA_W | Forwarded data |
| wr_reject | output | 1 | Write lost at least one requested lane |
| illegal_err | output | 1 | Sticky flag: a group held code 11 |
| src_code | output | 2*DATA_W/8 | Per-group source code {high, low} |

## Verification
The bench builds the arbiter with DATA_W=32 and REG_OUT=1. This gives four groups, so all four master codes can own at least one group or be shut out. A single guarded write can then mix owned and unowned lanes, and one group can be driven into the illegal code while its neighbours keep legal owners. The registered output stage puts every forwarding decision one clock after the access. The bench samples there, and the source update and the sticky flag's extra cycle can each be observed separately.

// File: rtl/cmdsrc_pkg.sv
package cmdsrc_pkg;
   // master identifiers carried with each access
   typedef enum logic [1:0] {
      MST_PRIMARY = 2'd0,
      MST_HOST    = 2'd1,
      MST_COPRO   = 2'd2,
      MST_RSVD    = 2'd3
   } master_e;

   // target classes of an access
   typedef enum logic [1:0] {
      TGT_GUARDED = 2'd0,
      TGT_SRC_LO  = 2'd1,
      TGT_SRC_HI  = 2'd2,
      TGT_OPEN    = 2'd3
   } target_e;

   localparam int unsigned LANE_W   = 8;
   localparam logic [1:0]  CODE_BAD = 2'b11;
endpackage

// File: rtl/cmdsrc_regs.sv
module cmdsrc_regs
   import cmdsrc_pkg::*;
#(
   parameter int unsigned NG = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_lo,
   input  logic            wr_hi,
   input  logic [NG-1:0]   lane_en,
   input  logic [NG-1:0]   wr_bits,
   input  logic            err_clr,
   output logic [2*NG-1:0] code,
   output logic            ill_err
);
   logic [NG-1:0] lo_q;
   logic [NG-1:0] hi_q;
   logic [NG-1:0] bad_grp;
   logic          any_bad;
   logic          err_q;

   for (genvar g = 0; g < NG; g++) begin : g_grp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_q[g] <= 1'b0;
            hi_q[g] <= 1'b0;
         end else begin
            if (wr_lo && lane_en[g]) lo_q[g] <= wr_bits[g];
            if (wr_hi && lane_en[g]) hi_q[g] <= wr_bits[g];
         end
      end
      assign code[2*g+1:2*g] = {hi_q[g], lo_q[g]};
      assign bad_grp[g]      = ({hi_q[g], lo_q[g]} == CODE_BAD);
   end

   assign any_bad = |bad_grp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= (err_q & ~err_clr) | any_bad;
   end

   assign ill_err = err_q;
endmodule

// File: rtl/cmdsrc_own.sv
module cmdsrc_own
   import cmdsrc_pkg::*;
#(
   parameter int unsigned NG = 4
) (
   input  logic [2*NG-1:0] code,
   input  logic [1:0]      master,
   input  logic [1:0]      target,
   output logic [NG-1:0]   perm
);
   logic [NG-1:0] owned;
   logic          is_primary;

   assign is_primary = (master == MST_PRIMARY);

   for (genvar g = 0; g < NG; g++) begin : g_own
      logic [1:0] c;
      assign c        = code[2*g+1:2*g];
      assign owned[g] = (c == master) && (c != CODE_BAD);
   end

   always_comb begin
      unique case (target)
         TGT_GUARDED:         perm = owned;
         TGT_SRC_LO,
         TGT_SRC_HI:          perm = {NG{is_primary}};
         default:             perm = {NG{1'b1}};
      endcase
   end
endmodule

// File: rtl/cmdsrc_gate.sv
module cmdsrc_gate
   import cmdsrc_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter bit          REG_OUT = 1'b1,
   localparam int unsigned NG     = DATA_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [1:0]        acc_target,
   input  logic [NG-1:0]     acc_be,
   input  logic [DATA_W-1:0] acc_data,
   input  logic [NG-1:0]     perm,
   output logic              fwd_valid,
   output logic              fwd_write,
   output logic [1:0]        fwd_target,
   output logic [NG-1:0]     fwd_be,
   output logic [DATA_W-1:0] fwd_data,
   output logic              wr_reject
);
   logic [NG-1:0] allow_be;
   logic [NG-1:0] deny_be;
   logic          is_src;
   logic          n_valid;
   logic [NG-1:0] n_be;
   logic          n_rej;

   always_comb begin
      allow_be = acc_be & perm;
      deny_be  = acc_be & ~perm;
      is_src   = (acc_target == TGT_SRC_LO) || (acc_target == TGT_SRC_HI);
      n_valid  = acc_valid && !is_src && (!acc_write || (|allow_be));
      n_be     = acc_write ? allow_be : acc_be;
      n_rej    = acc_valid && acc_write && (|deny_be);
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            fwd_valid  <= 1'b0;
            fwd_write  <= 1'b0;
            fwd_target <= 2'd0;
            fwd_be     <= '0;
            fwd_data   <= '0;
            wr_reject  <= 1'b0;
         end else begin
            fwd_valid  <= n_valid;
            fwd_write  <= acc_write;
            fwd_target <= acc_target;
            fwd_be     <= n_be;
            fwd_data   <= acc_data;
            wr_reject  <= n_rej;
         end
      end
   end else begin : g_comb
      assign fwd_valid  = n_valid;
      assign fwd_write  = acc_write;
      assign fwd_target = acc_target;
      assign fwd_be     = n_be;
      assign fwd_data   = acc_data;
      assign wr_reject  = n_rej;
   end
endmodule

// File: rtl/cmdsrc_arb.sv
module cmdsrc_arb
   import cmdsrc_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter bit          REG_OUT = 1'b1,
   localparam int unsigned NG     = DATA_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [1:0]        acc_master,
   input  logic [1:0]        acc_target,
   input  logic [NG-1:0]     acc_be,
   input  logic [DATA_W-1:0] acc_data,
   input  logic              err_clr,
   output logic              fwd_valid,
   output logic              fwd_write,
   output logic [1:0]        fwd_target,
   output logic [NG-1:0]     fwd_be,
   output logic [DATA_W-1:0] fwd_data,
   output logic              wr_reject,
   output logic              illegal_err,
   output logic [2*NG-1:0]   src_code
);
   if (DATA_W % LANE_W != 0) begin : g_bad_width
      $error("DATA_W must be a whole number of byte lanes");
   end
   if (DATA_W < LANE_W) begin : g_too_narrow
      $error("DATA_W must hold at least one group");
   end

   logic          src_ok;
   logic          wr_lo;
   logic          wr_hi;
   logic [NG-1:0] wr_bits;
   logic [NG-1:0] perm;

   assign src_ok = acc_valid && acc_write && (acc_master == MST_PRIMARY);
   assign wr_lo  = src_ok && (acc_target == TGT_SRC_LO);
   assign wr_hi  = src_ok && (acc_target == TGT_SRC_HI);

   for (genvar g = 0; g < NG; g++) begin : g_bits
      assign wr_bits[g] = acc_data[g*LANE_W];
   end

   cmdsrc_regs #(.NG(NG)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_lo   (wr_lo),
      .wr_hi   (wr_hi),
      .lane_en (acc_be),
      .wr_bits (wr_bits),
      .err_clr (err_clr),
      .code    (src_code),
      .ill_err (illegal_err)
   );

   cmdsrc_own #(.NG(NG)) u_own (
      .code   (src_code),
      .master (acc_master),
      .target (acc_target),
      .perm   (perm)
   );

   cmdsrc_gate #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_valid  (acc_valid),
      .acc_write  (acc_write),
      .acc_target (acc_target),
      .acc_be     (acc_be),
      .acc_data   (acc_data),
      .perm       (perm),
      .fwd_valid  (fwd_valid),
      .fwd_write  (fwd_write),
      .fwd_target (fwd_target),
      .fwd_be     (fwd_be),
      .fwd_data   (fwd_data),
      .wr_reject  (wr_reject)
   );
endmodule

// File: rtl/cmdsrc_arb_chk.sv
module cmdsrc_arb_chk #(
   parameter int unsigned DATA_W  = 32,
   parameter bit          REG_OUT = 1'b1,
   localparam int unsigned NG     = DATA_W / 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic              acc_write,
   input logic [1:0]        acc_master,
   input logic [1:0]        acc_target,
   input logic [NG-1:0]     acc_be,
   input logic              err_clr,
   input logic              fwd_valid,
   input logic [NG-1:0]     fwd_be,
   input logic              wr_reject,
   input logic              illegal_err,
   input logic [2*NG-1:0]   src_code
);
   logic [NG-1:0] bad_mask;
   logic          src_tgt;

   always_comb begin
      for (int g = 0; g < NG; g++) bad_mask[g] = &src_code[2*g +: 2];
   end
   assign src_tgt = (acc_target == 2'd1) || (acc_target == 2'd2);

   // R9: flag rises after an illegal code is held
   p_flag_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|bad_mask) |=> illegal_err);

   // R9: flag stays set without a clear
   p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (illegal_err && !err_clr) |=> illegal_err);

   if (REG_OUT) begin : g_seq
      // R3: foreign write to a source register
      p_src_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_valid && acc_write && src_tgt && acc_master != 2'd0 && (|acc_be))
         |=> (wr_reject && !fwd_valid && $stable(src_code)));

      // R6: reads always pass
      p_read_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_valid && !acc_write && !src_tgt)
         |=> (fwd_valid && !wr_reject && fwd_be == $past(acc_be)));

      // R7: unguarded writes always pass
      p_open_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_valid && acc_write && acc_target == 2'd3 && (|acc_be))
         |=> (fwd_valid && !wr_reject && fwd_be == $past(acc_be)));

      // R8: lanes of illegal groups never granted
      p_bad_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_valid && acc_write && acc_target == 2'd0 && ((acc_be & bad_mask) != '0))
         |=> (wr_reject && ((fwd_be & $past(bad_mask)) == '0)));
   end
endmodule

bind cmdsrc_arb cmdsrc_arb_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .acc_valid   (acc_valid),
   .acc_write   (acc_write),
   .acc_master  (acc_master),
   .acc_target  (acc_target),
   .acc_be      (acc_be),
   .err_clr     (err_clr),
   .fwd_valid   (fwd_valid),
   .fwd_be      (fwd_be),
   .wr_reject   (wr_reject),
   .illegal_err (illegal_err),
   .src_code    (src_code)
);

// File: tb/cmdsrc_arb_test.sv
module cmdsrc_arb_test;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int NB = DW / 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acc_valid = 1'b0;
   logic          acc_write = 1'b0;
   logic [1:0]    acc_master = 2'd0;
   logic [1:0]    acc_target = 2'd0;
   logic [NB-1:0] acc_be = '0;
   logic [DW-1:0] acc_data = '0;
   logic          err_clr = 1'b0;
   logic          fwd_valid, fwd_write, wr_reject, illegal_err;
   logic [1:0]    fwd_target;
   logic [NB-1:0] fwd_be;
   logic [DW-1:0] fwd_data;
   logic [2*NB-1:0] src_code;

   int n_checks = 0;
   int n_errs = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmdsrc_arb #(.DATA_W(DW), .REG_OUT(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_master(acc_master), .acc_target(acc_target), .acc_be(acc_be),
      .acc_data(acc_data), .err_clr(err_clr), .fwd_valid(fwd_valid),
      .fwd_write(fwd_write), .fwd_target(fwd_target), .fwd_be(fwd_be),
      .fwd_data(fwd_data), .wr_reject(wr_reject), .illegal_err(illegal_err),
      .src_code(src_code)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // one access; returns at the negedge after the capturing edge
   task automatic access(input logic wr, input logic [1:0] m, input logic [1:0] tgt,
                         input logic [NB-1:0] be, input logic [DW-1:0] d);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = wr; acc_master = m;
      acc_target = tgt; acc_be = be; acc_data = d;
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0; acc_be = '0;
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   task automatic pulse_clear();
      @(negedge clk);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 src_code", src_code, 0);
      check("R1 illegal_err", illegal_err, 0);
      check("R1 fwd_valid", fwd_valid, 0);
      check("R1 wr_reject", wr_reject, 0);
   endtask

   task automatic t_program();
      access(1, 2'd0, 2'd2, 4'hF, 32'h0000_0100);
      check("R2 high write no fwd", fwd_valid, 0);
      access(1, 2'd0, 2'd1, 4'hF, 32'h0001_0000);
      check("R2 codes after two writes", src_code, 8'h18);
      access(1, 2'd0, 2'd1, 4'h1, 32'hFFFF_FFFF);
      check("R2 lane-limited write", src_code, 8'h19);
      access(1, 2'd0, 2'd1, 4'h1, 32'h0);
      check("R2 restore group0", src_code, 8'h18);
   endtask

   task automatic t_src_reject();
      access(1, 2'd1, 2'd1, 4'hF, 32'hFFFF_FFFF);
      check("R3 reject flag", wr_reject, 1);
      check("R3 not forwarded", fwd_valid, 0);
      idle();
      check("R3 codes unchanged", src_code, 8'h18);
   endtask

   task automatic t_owner();
      access(1, 2'd2, 2'd0, 4'h2, 32'hA5A5_A5A5);
      check("R4 fwd_valid", fwd_valid, 1);
      check("R4 fwd_be", fwd_be, 4'h2);
      check("R4 fwd_data", fwd_data, 32'hA5A5_A5A5);
      check("R4 fwd_write", fwd_write, 1);
      check("R4 fwd_target", fwd_target, 0);
      check("R4 no reject", wr_reject, 0);
   endtask

   task automatic t_multi();
      access(1, 2'd1, 2'd0, 4'hF, 32'h1234_5678);
      check("R5 host lanes", fwd_be, 4'h4);
      check("R5 host valid", fwd_valid, 1);
      check("R5 host reject", wr_reject, 1);
      access(1, 2'd0, 2'd0, 4'hF, 32'h1234_5678);
      check("R5 primary lanes", fwd_be, 4'h9);
      check("R5 primary reject", wr_reject, 1);
      access(1, 2'd1, 2'd0, 4'h1, 32'h0);
      check("R5 nothing left valid", fwd_valid, 0);
      check("R5 nothing left reject", wr_reject, 1);
   endtask

   task automatic t_reads();
      access(0, 2'd1, 2'd0, 4'hF, 32'h0);
      check("R6 read valid", fwd_valid, 1);
      check("R6 read be", fwd_be, 4'hF);
      check("R6 read no reject", wr_reject, 0);
      check("R6 read write flag", fwd_write, 0);
      access(0, 2'd3, 2'd3, 4'h3, 32'h0);
      check("R6 reserved read valid", fwd_valid, 1);
   endtask

   task automatic t_open();
      access(1, 2'd1, 2'd3, 4'hF, 32'hDEAD_BEEF);
      check("R7 open valid", fwd_valid, 1);
      check("R7 open be", fwd_be, 4'hF);
      check("R7 open no reject", wr_reject, 0);
      check("R7 open target", fwd_target, 3);
   endtask

   task automatic t_illegal();
      access(1, 2'd0, 2'd1, 4'h2, 32'h0000_0100);
      check("R8 group1 now 11", src_code, 8'h1C);
      check("R9 flag not yet", illegal_err, 0);
      idle();
      check("R9 flag set", illegal_err, 1);
      access(1, 2'd3, 2'd0, 4'h2, 32'h0);
      check("R8 reserved master denied", fwd_valid, 0);
      check("R8 reserved master reject", wr_reject, 1);
      access(1, 2'd2, 2'd0, 4'h2, 32'h0);
      check("R8 coprocessor denied", wr_reject, 1);
      pulse_clear();
      check("R9 clear ignored while illegal", illegal_err, 1);
      access(1, 2'd0, 2'd2, 4'h2, 32'h0);
      check("R2 group1 now host", src_code, 8'h14);
      idle();
      check("R9 still sticky", illegal_err, 1);
      pulse_clear();
      check("R9 cleared", illegal_err, 0);
      access(1, 2'd1, 2'd0, 4'h2, 32'h0);
      check("R4 host owns group1", fwd_be, 4'h2);
   endtask

   task automatic t_latency();
      @(negedge clk);
      acc_valid = 1'b1; acc_write = 1'b1; acc_master = 2'd1;
      acc_target = 2'd3; acc_be = 4'h1; acc_data = 32'h1;
      #1;
      check("R10 not yet visible", fwd_valid, 0);
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0; acc_be = '0;
      check("R10 visible after one edge", fwd_valid, 1);
      idle();
      check("R10 drops after idle", fwd_valid, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_program();
      t_src_reject();
      t_owner();
      t_multi();
      t_reads();
      t_open();
      t_illegal();
      t_latency();
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errs++;
         $display("FAIL watchdog actual running expected done");
         $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
         $finish;
      end
   end
endmodule